// File: doc/BRIEF.md
# Chainable FIFO Slice for Depth Expansion

This block is one storage slice of a deeper first-in/first-out buffer built by chaining several identical slices in a ring. Every slice sees the same write strobe, write data and read strobe. The outputs of all slices are OR-ed into one read-data bus. Two ownership tokens travel around the ring, one for writing and one for reading. Only the slice that holds the write token stores words. Only the slice that holds the read token supplies and removes words.

When a slice accepts an access to its last physical location, it raises its hand-over pulse in that same cycle. A type bit marks the pulse as write-caused or read-caused. The pulse drives the hand-over input of the next slice, which claims the matching token at the same clock edge. A first-load input picks the slice that owns both tokens after reset. Each slice reports full and empty only while it holds the token concerned. The composite flags are formed outside the slices by combining the active-low local flags.

Top module: `cfifo_slice`

## Requirements
- R1: After reset, a slice with first_load_n low holds both tokens, reports empty_n=0 and full_n=1, and drives rd_data to zero. A slice with first_load_n high holds no token and reports empty_n=1 and full_n=1. Both pointers of every slice start at location 0.
- R2: A slice stores wr_data on a clock edge with wr_en high only while it holds the write token and its local count is below DEPTH. The word goes into the next location, and locations are filled in order from 0 to DEPTH-1.
- R3: A slice removes its oldest word on a clock edge with rd_en high only while it holds the read token and its local count is above zero. Words leave in the order they were written.
- R4: An accepted write to location DEPTH-1 raises xo_pulse with xo_type=1 in the same cycle. The slice gives up the write token at that edge.
- R5: An accepted read from location DEPTH-1 raises xo_pulse with xo_type=0 in the same cycle. The slice gives up the read token at that edge.
- R6: An xi_pulse with xi_type=1 hands the write token to the slice at that edge. An xi_pulse with xi_type=0 hands it the read token.
- R7: full_n is 0 exactly when the slice holds the write token and holds DEPTH words. empty_n is 0 exactly when the slice holds the read token and holds zero words.
- R8: rd_data shows the oldest stored word while the slice holds the read token and is not empty. Otherwise rd_data is zero.
- R9: A ring of slices behaves as one FIFO of (slices x DEPTH) words. Order is kept across slice boundaries and across wrap-around of both tokens.
- R10: A write strobe while the composite full flag is asserted has no effect. The word is never read out, and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_load_n | input | 1 | Low marks the slice that owns both tokens after reset |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | WIDTH | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | WIDTH | Oldest word while this slice holds the read token, otherwise zero |
| xi_pulse | input | 1 | Hand-over pulse from the previous slice |
| xi_type | input | 1 | 1 = write token arriving, 0 = read token arriving |
| xo_pulse | output | 1 | Hand-over pulse to the next slice |
| xo_type | output | 1 | 1 = write-caused pulse, 0 = read-caused pulse |
| full_n | output | 1 | Active-low local full flag |
| empty_n | output | 1 | Active-low local empty flag |

## Verification
The embedded assertions check the following on every cycle:
- the local count never exceeds DEPTH and moves by exactly one per accepted access;
- a pointer returns to location 0 after an access to the last location;
- a token is released when it is passed on and taken when it arrives;
- write-caused and read-caused hand-over pulses never coincide.

Only the bench's scenarios can show the ring-level behaviour. These include FIFO order across slice boundaries, the composite flags, the per-slice count of hand-over pulses of each type, and the loss of a word written while the ring is full. Long mixed traffic drives both tokens around the ring several times.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  typedef enum logic {TOK_READ = 1'b0, TOK_WRITE = 1'b1} tok_kind_t;

  // Next position of a ring pointer over a memory of 'depth' locations
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // True when a pointer addresses the last physical location
  function automatic bit at_last(int unsigned ptr, int unsigned depth);
    return ptr == depth - 1;
  endfunction
endpackage

// File: rtl/cfifo_token.sv
module cfifo_token
  import cfifo_pkg::*;
#(
  parameter tok_kind_t KIND = TOK_WRITE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first_load_n,
  input  logic xi_pulse,
  input  logic xi_type,
  input  logic pass_out,
  output logic held
);
  logic take_in;
  assign take_in = xi_pulse && (xi_type == logic'(KIND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held <= ~first_load_n;
    else if (take_in)  held <= 1'b1;
    else if (pass_out) held <= 1'b0;
  end

  // R4 / R5: a token that is passed on and not returned is gone after the edge
  assert_token_leaves_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_out && !take_in) |=> !held);
  // R6: an arriving pulse of the matching kind hands the token over
  assert_token_arrives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_in |=> held);
endmodule

// File: rtl/cfifo_store.sv
module cfifo_store
  import cfifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc,
  input  logic             rd_acc,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] head,
  output logic             wr_last,
  output logic             rd_last,
  output logic             is_full,
  output logic             is_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;

  assign wr_last  = wr_acc && at_last(int'(wr_ptr), DEPTH);
  assign rd_last  = rd_acc && at_last(int'(rd_ptr), DEPTH);
  assign is_full  = (cnt == CW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_acc) wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (rd_acc) rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      if (wr_acc && !rd_acc)      cnt <= cnt + CW'(1);
      else if (rd_acc && !wr_acc) cnt <= cnt - CW'(1);
    end
  end

  // R2: a write never lands on a full slice
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R2: a lone write grows the count by one
  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc) |=> cnt == $past(cnt) + CW'(1));
  // R3: a lone read shrinks the count by one
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !wr_acc) |=> cnt == $past(cnt) - CW'(1));
  // R4: write pointer wraps to location 0 after the last location
  assert_wr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> wr_ptr == '0);
  // R5: read pointer wraps to location 0 after the last location
  assert_rd_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> rd_ptr == '0);
endmodule

// File: rtl/cfifo_slice.sv
module cfifo_slice
  import cfifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             xi_pulse,
  input  logic             xi_type,
  output logic             xo_pulse,
  output logic             xo_type,
  output logic             full_n,
  output logic             empty_n
);
  logic wr_tok, rd_tok;
  logic wr_acc, rd_acc;
  logic wr_last, rd_last;
  logic is_full, is_empty;
  logic [WIDTH-1:0] head;

  assign wr_acc = wr_en && wr_tok && !is_full;
  assign rd_acc = rd_en && rd_tok && !is_empty;

  cfifo_token #(.KIND(TOK_WRITE)) u_wtok (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .xi_pulse(xi_pulse), .xi_type(xi_type), .pass_out(wr_last), .held(wr_tok)
  );

  cfifo_token #(.KIND(TOK_READ)) u_rtok (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .xi_pulse(xi_pulse), .xi_type(xi_type), .pass_out(rd_last), .held(rd_tok)
  );

  cfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .wr_data(wr_data), .head(head), .wr_last(wr_last), .rd_last(rd_last),
    .is_full(is_full), .is_empty(is_empty)
  );

  assign xo_pulse = wr_last || rd_last;
  assign xo_type  = wr_last;
  assign full_n   = !(wr_tok && is_full);
  assign empty_n  = !(rd_tok && is_empty);
  assign rd_data  = (rd_tok && !is_empty) ? head : '0;

  // R4 / R5: write- and read-caused hand-overs cannot share one pulse
  assert_single_handover_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_last && rd_last));
  // R7: a slice never flags full and empty together
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n));
endmodule

// File: tb/cfifo_slice_tb_top.sv
module cfifo_slice_tb_top;
  localparam int W = 9;
  localparam int D = 4;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [N-1:0] xo, xo_t, fn, en;
  logic [W-1:0] rdd [N];

  always #4 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_ring
    if (i == 0) begin : g_first
      cfifo_slice #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b0),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rdd[i]),
        .xi_pulse(xo[N-1]), .xi_type(xo_t[N-1]),
        .xo_pulse(xo[i]), .xo_type(xo_t[i]), .full_n(fn[i]), .empty_n(en[i]));
    end else begin : g_rest
      cfifo_slice #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b1),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rdd[i]),
        .xi_pulse(xo[i-1]), .xi_type(xo_t[i-1]),
        .xo_pulse(xo[i]), .xo_type(xo_t[i]), .full_n(fn[i]), .empty_n(en[i]));
    end
  end

  logic comp_full, comp_empty;
  logic [W-1:0] rd_bus;
  assign comp_full  = ~&fn;
  assign comp_empty = ~&en;
  assign rd_bus     = rdd[0] | rdd[1] | rdd[2];

  int checks = 0, errors = 0;
  logic [W-1:0] q [$];
  int wpulse [N];
  int rpulse [N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected word queued when the ring can take it (R2, R10)
  task automatic step(input bit w, input logic [W-1:0] d, input bit r);
    @(posedge clk); #1;
    wr_en = w; wr_data = d; rd_en = r;
    if (w && !comp_full) q.push_back(d);
  endtask

  // Monitor: compares each accepted read against the model queue (R3, R8, R9)
  always @(negedge clk) begin
    if (rst_n && rd_en && !comp_empty) begin
      if (q.size() == 0) chk(1'b0, "R3 read from model-empty ring", int'(rd_bus), 0);
      else begin
        chk(rd_bus == q[0], "R9 FIFO order", int'(rd_bus), int'(q[0]));
        void'(q.pop_front());
      end
    end
  end

  // Per-slice hand-over pulse counters, split by type (R4, R5)
  always @(posedge clk) begin
    if (rst_n) for (int i = 0; i < N; i++) if (xo[i]) begin
      if (xo_t[i]) wpulse[i]++; else rpulse[i]++;
    end
  end

  initial begin : watchdog
    #1000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) begin wpulse[i] = 0; rpulse[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(en == 3'b110, "R1 empty_n after reset", int'(en), 6);
    chk(fn == 3'b111, "R1 full_n after reset", int'(fn), 7);
    chk(rd_bus == '0, "R1 rd_data zero after reset", int'(rd_bus), 0);
    chk(xo == '0, "R1 no hand-over after reset", int'(xo), 0);

    // R2/R4/R6: fill slice 0, token moves to slice 1
    for (int i = 0; i < D; i++) step(1'b1, W'(9'h100 + i), 1'b0);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk(wpulse[0] == 1 && xo_t == xo_t, "R4 write pulse from slice 0", wpulse[0], 1);
    chk(wpulse[1] == 0, "R4 no write pulse from slice 1 yet", wpulse[1], 0);
    chk(en == 3'b111, "R7 holder not empty after writes", int'(en), 7);
    chk(rd_bus == 9'h100, "R8 head word on bus", int'(rd_bus), 'h100);
    for (int i = D; i < 2*D; i++) step(1'b1, W'(9'h100 + i), 1'b0);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk(wpulse[1] == 1, "R6 slice 1 took write token and passed it", wpulse[1], 1);
    for (int i = 2*D; i < 3*D; i++) step(1'b1, W'(9'h100 + i), 1'b0);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk(wpulse[2] == 1, "R4 write pulse from slice 2", wpulse[2], 1);
    chk(fn == 3'b110, "R7 slice 0 full with write token back", int'(fn), 6);
    chk(comp_full == 1'b1, "R9 ring full after N*DEPTH writes", int'(comp_full), 1);

    // R10: write while full is ignored
    step(1'b1, 9'h1FF, 1'b0);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk(fn == 3'b110, "R10 flags unchanged by write while full", int'(fn), 6);
    chk(wpulse[0] == 1, "R10 no pulse from ignored write", wpulse[0], 1);

    // R3/R5: drain the whole ring
    for (int i = 0; i < N*D; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk(q.size() == 0, "R10 ignored word never queued, all drained", q.size(), 0);
    chk(rpulse[0] == 1 && rpulse[1] == 1 && rpulse[2] == 1, "R5 one read pulse per slice",
        rpulse[0] + rpulse[1] + rpulse[2], 3);
    chk(en == 3'b110, "R7 slice 0 empty with read token back", int'(en), 6);
    chk(fn == 3'b111, "R7 no full flag after drain", int'(fn), 7);

    // R3/R8: read while empty does nothing
    step(1'b0, '0, 1'b1);
    @(negedge clk);
    chk(rd_bus == '0, "R8 zero bus while empty", int'(rd_bus), 0);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk(rpulse[0] == 1, "R3 read on empty ring takes no location", rpulse[0], 1);

    // R9: mixed traffic, both tokens wrap several times
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], W'(lfsr[11:3]), lfsr[1] | (i > 300 && lfsr[5]));
    end
    for (int i = 0; i < N*D + 2; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk(q.size() == 0, "R9 mixed traffic fully drained", q.size(), 0);
    chk(wpulse[0] >= 2 && rpulse[0] >= 2, "R9 tokens wrapped the ring", wpulse[0], 2);
    chk(comp_empty == 1'b1, "R7 ring empty at end", int'(comp_empty), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule